// File: doc/BRIEF.md
# Variable Page-Size Translation Lookaside Buffer

This block is a small, fully associative address translation cache. Each slot holds a tag word and a data word. The tag word has a virtual tag, a two-bit page size code, a flush-protection bit and a valid bit. The data word has the physical frame and a set of attribute bits. Every slot carries its own page size, so the tag compare for each slot uses a different mask. A 16 MiB slot compares only the top byte of the address, and a 4 KiB slot compares twenty bits.

A lookup presents a 32-bit device address. One cycle later the block returns exactly one of three outcomes:
- a hit, with the translated physical address;
- a miss;
- a multi-hit fault, when two or more valid slots claim the address.

Software-side logic fills slots through a load port, which rejects tags that are not aligned to their page size. It inspects slots through a combinational read port. It invalidates slots either with a global flush, which spares protected slots, or with an address-directed flush.

Top module: `tlb_top`

## Requirements
- R1: After reset every slot is invalid and reads back as all-zero tag and data words; respValid, respHit, respMiss, respMulti and loadErr are low.
- R2: Page size codes in tag bits [2:1] select the compare mask: 0 → 0xFF000000 (16 MiB), 1 → 0xFFF00000 (1 MiB), 2 → 0xFFFF0000 (64 KiB), 3 → 0xFFFFF000 (4 KiB). On a hit, respPhys equals (data word AND mask) OR (lookup address AND NOT mask).
- R3: The tag word layout is [31:12] virtual tag, [3] protected, [2:1] size code, [0] valid. A successful load stores the tag, protect bit and size code, and forces valid to 1. Tag bits [11:4] and bit 0 of loadCam are ignored and read back as zero and one respectively. The data word is stored and read back unchanged.
- R4: A load whose tag has any bit set in [31:12] outside the page-size mask is rejected: the slot is left unchanged, and loadErr is high in the cycle after the request (and low after any cycle without a load, or with an aligned one).
- R5: A lookup request in cycle n gives respValid in cycle n+1, with exactly one of respHit, respMiss, respMulti high. With no request, all four are low.
- R6: A lookup that matches no valid slot reports respMiss with respPhys zero.
- R7: A lookup that matches two or more valid slots reports respMulti with respPhys zero.
- R8: A slot whose valid bit is clear never takes part in a match.
- R9: A global flush clears the valid bit of every slot whose protect bit is 0 and leaves protected slots valid.
- R10: An address-directed flush clears the valid bit of every slot whose tag matches flushAddr under that slot's own mask, protected or not.
- R11: When load, flush and lookup fall in the same cycle, the lookup sees the contents before that cycle, the flushes are applied, and a successful load then sets its slot regardless of the flushes.
- R12: readCam and readRam show, without delay, the current contents of the slot at readIndex, including its present valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | 32 | Device address to translate |
| respValid | output | 1 | Lookup result valid (one cycle after request) |
| respHit | output | 1 | Exactly one slot matched |
| respMiss | output | 1 | No slot matched |
| respMulti | output | 1 | Two or more slots matched |
| respPhys | output | 32 | Translated physical address on hit, else zero |
| loadValid | input | 1 | Load request |
| loadIndex | input | 3 | Slot to load |
| loadCam | input | 32 | Tag word to load |
| loadRam | input | 32 | Data word to load |
| loadErr | output | 1 | Previous load was rejected as misaligned |
| flushAll | input | 1 | Invalidate all unprotected slots |
| flushOne | input | 1 | Invalidate slots matching flushAddr |
| flushAddr | input | 32 | Address for the directed flush |
| readIndex | input | 3 | Slot to inspect |
| readCam | output | 32 | Tag word of the inspected slot |
| readRam | output | 32 | Data word of the inspected slot |

## Verification
Tags are drawn from a deliberately tiny pool, so slots of different sizes overlap often. A design that used one global mask, or that picked the first match instead of counting, would return a physical address where a multi-hit is due. Misaligned loads are mixed in. A design that stored them anyway would show the changed slot on the read port and mistranslate later lookups. Load, both flushes and a lookup are driven in the same cycle, which exposes three kinds of fault. A lookup that used the post-write contents gives the wrong status. A flush that overrode a load loses the new entry. A global flush that ignored the protect bit drops slots that should survive.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic flushAll;
    logic flushOne;
    logic lookup;
  } tlbStrobes_t;

  // Compare mask for a page size code
  function automatic logic [31:0] sizeMask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'hFF00_0000;
      2'd1:    return 32'hFFF0_0000;
      2'd2:    return 32'hFFFF_0000;
      default: return 32'hFFFF_F000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  logic [31:0] loadCam,
  input  logic        flushAll,
  input  logic        flushOne,
  input  logic        lookupValid,
  output tlbStrobes_t strobes,
  output logic        loadErr
);
  logic [31:0] loadMask;
  logic        misaligned;

  assign loadMask   = sizeMask(loadCam[2:1]);
  assign misaligned = |(loadCam[31:12] & ~loadMask[31:12]);

  always_comb begin
    strobes.wrEn     = loadValid && !misaligned;
    strobes.flushAll = flushAll;
    strobes.flushOne = flushOne;
    strobes.lookup   = lookupValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) loadErr <= 1'b0;
    else       loadErr <= loadValid && misaligned;
  end

  // R4: a misaligned load is flagged on the next cycle
  a_r4_reject_flag: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && misaligned) |=> loadErr);
  // R4: no load, no error flag
  a_r4_quiet_flag: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |=> !loadErr);
endmodule

// File: rtl/tlb_datapath.sv
`timescale 1ns/1ps
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  tlbStrobes_t                    strobes,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIdx,
  input  logic [31:0]                    wrCam,
  input  logic [31:0]                    wrRam,
  input  logic [31:0]                    flushAddr,
  input  logic [31:0]                    lookupAddr,
  input  logic [$clog2(NUM_ENTRIES)-1:0] readIndex,
  output logic [31:0]                    readCam,
  output logic [31:0]                    readRam,
  output logic                           respValid,
  output logic                           respHit,
  output logic                           respMiss,
  output logic                           respMulti,
  output logic [31:0]                    respPhys
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  logic [19:0]            tagQ  [NUM_ENTRIES];
  logic [1:0]             sizeQ [NUM_ENTRIES];
  logic [31:0]            ramQ  [NUM_ENTRIES];
  logic [31:0]            maskArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ, presQ, matchVec, flushHit;
  logic [CNT_W-1:0]       matchCnt;
  logic [31:0]            physNext;

  // Per-slot compare against lookup and flush addresses
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gSlot
    assign maskArr[g]  = sizeMask(sizeQ[g]);
    assign matchVec[g] = validQ[g] &&
      ((lookupAddr & maskArr[g]) == ({tagQ[g], 12'h000} & maskArr[g]));
    assign flushHit[g] =
      ((flushAddr & maskArr[g]) == ({tagQ[g], 12'h000} & maskArr[g]));
  end

  // Slot storage: flushes first, a load wins on its own slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      presQ  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i]  <= '0;
        sizeQ[i] <= '0;
        ramQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.wrEn && wrIdx == IDX_W'(i)) begin
          tagQ[i]   <= wrCam[31:12];
          sizeQ[i]  <= wrCam[2:1];
          presQ[i]  <= wrCam[3];
          ramQ[i]   <= wrRam;
          validQ[i] <= 1'b1;
        end else if ((strobes.flushAll && !presQ[i]) ||
                     (strobes.flushOne && flushHit[i])) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  // Match count and OR-merged translation
  always_comb begin
    matchCnt = '0;
    physNext = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) begin
        matchCnt = matchCnt + CNT_W'(1);
        physNext = physNext | (ramQ[i] & maskArr[i]) | (lookupAddr & ~maskArr[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respMulti <= 1'b0;
      respPhys  <= '0;
    end else begin
      respValid <= strobes.lookup;
      respHit   <= strobes.lookup && matchCnt == CNT_W'(1);
      respMiss  <= strobes.lookup && matchCnt == '0;
      respMulti <= strobes.lookup && matchCnt > CNT_W'(1);
      respPhys  <= (strobes.lookup && matchCnt == CNT_W'(1)) ? physNext : '0;
    end
  end

  assign readCam = {tagQ[readIndex], 8'h00, presQ[readIndex], sizeQ[readIndex], validQ[readIndex]};
  assign readRam = ramQ[readIndex];

  // R5: one outcome per response, none without
  a_r5_one_status: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, respMiss, respMulti}));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respMulti));
  // R5: response one cycle after request
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookup |=> respValid);
  // R6, R7: no address on miss or multi-hit
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> respPhys == '0);
  a_r7_multi_zero: assert property (@(posedge clk) disable iff (!rstN)
    respMulti |-> respPhys == '0);
  // R9: global flush leaves only protected slots valid
  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flushAll && !strobes.wrEn) |=> (validQ & ~presQ) == '0);
endmodule

// File: rtl/tlb_top.sv
`timescale 1ns/1ps
module tlb_top
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lookupValid,
  input  logic [31:0]                    lookupAddr,
  output logic                           respValid,
  output logic                           respHit,
  output logic                           respMiss,
  output logic                           respMulti,
  output logic [31:0]                    respPhys,
  input  logic                           loadValid,
  input  logic [$clog2(NUM_ENTRIES)-1:0] loadIndex,
  input  logic [31:0]                    loadCam,
  input  logic [31:0]                    loadRam,
  output logic                           loadErr,
  input  logic                           flushAll,
  input  logic                           flushOne,
  input  logic [31:0]                    flushAddr,
  input  logic [$clog2(NUM_ENTRIES)-1:0] readIndex,
  output logic [31:0]                    readCam,
  output logic [31:0]                    readRam
);
  tlbStrobes_t strobes;

  tlb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadCam(loadCam),
    .flushAll(flushAll), .flushOne(flushOne), .lookupValid(lookupValid),
    .strobes(strobes), .loadErr(loadErr)
  );

  tlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(loadIndex),
    .wrCam(loadCam), .wrRam(loadRam), .flushAddr(flushAddr),
    .lookupAddr(lookupAddr), .readIndex(readIndex), .readCam(readCam),
    .readRam(readRam), .respValid(respValid), .respHit(respHit),
    .respMiss(respMiss), .respMulti(respMulti), .respPhys(respPhys)
  );
endmodule

// File: tb/test_tlb_top.sv
`timescale 1ns/1ps
module test_tlb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        respValid, respHit, respMiss, respMulti;
  logic [31:0] respPhys;
  logic        loadValid = 1'b0;
  logic [2:0]  loadIndex = '0;
  logic [31:0] loadCam = '0, loadRam = '0;
  logic        loadErr;
  logic        flushAll = 1'b0, flushOne = 1'b0;
  logic [31:0] flushAddr = '0;
  logic [2:0]  readIndex = '0;
  logic [31:0] readCam, readRam;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 0;

  // Bench model of the slots
  logic [19:0] mTag [N];
  logic [1:0]  mSize [N];
  logic        mPres [N];
  logic        mValid [N];
  logic [31:0] mRam [N];

  always #10 clk = ~clk;

  tlb_top #(.NUM_ENTRIES(N)) i_tlb_top (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respMulti(respMulti), .respPhys(respPhys), .loadValid(loadValid),
    .loadIndex(loadIndex), .loadCam(loadCam), .loadRam(loadRam),
    .loadErr(loadErr), .flushAll(flushAll), .flushOne(flushOne),
    .flushAddr(flushAddr), .readIndex(readIndex), .readCam(readCam),
    .readRam(readRam)
  );

  function automatic logic [31:0] msk(input logic [1:0] c);
    case (c)
      2'd0: return 32'hFF000000;
      2'd1: return 32'hFFF00000;
      2'd2: return 32'hFFFF0000;
      default: return 32'hFFFFF000;
    endcase
  endfunction

  function automatic bit isMisaligned(input logic [31:0] cam);
    return ((cam & ~msk(cam[2:1]) & 32'hFFFFF000) != 0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < N; i++) begin
      readIndex = 3'(i);
      #1;
      chk(readCam == {mTag[i], 8'h00, mPres[i], mSize[i], mValid[i]}, req, readCam,
          {mTag[i], 8'h00, mPres[i], mSize[i], mValid[i]});
      chk(readRam == mRam[i], req, readRam, mRam[i]);
    end
  endtask

  // One cycle of any combination of operations, model updated after
  task automatic step(input bit ld, input int idx, input logic [31:0] cam, input logic [31:0] ram,
                      input bit fa, input bit fo, input logic [31:0] fadr,
                      input bit lk, input logic [31:0] la);
    int cnt;
    logic [31:0] ph, m;
    bit mis;
    string req;
    cnt = 0; ph = '0;
    for (int i = 0; i < N; i++) begin
      m = msk(mSize[i]);
      if (mValid[i] && ((la & m) == ({mTag[i], 12'h0} & m))) begin
        cnt++;
        ph = (mRam[i] & m) | (la & ~m);
      end
    end
    if (cnt != 1) ph = '0;
    mis = isMisaligned(cam);
    @(negedge clk);
    loadValid = ld; loadIndex = 3'(idx); loadCam = cam; loadRam = ram;
    flushAll = fa; flushOne = fo; flushAddr = fadr;
    lookupValid = lk; lookupAddr = la;
    @(negedge clk);
    loadValid = 0; flushAll = 0; flushOne = 0; lookupValid = 0;
    if (ld) chk(loadErr == mis, "R4", 32'(loadErr), 32'(mis));
    if (lk) begin
      req = (cnt == 0) ? "R6" : (cnt > 1) ? "R7" : "R2";
      chk({respValid, respHit, respMiss, respMulti} == {1'b1, cnt == 1, cnt == 0, cnt > 1},
          {req, "/R5 status"}, 32'({respValid, respHit, respMiss, respMulti}),
          32'({1'b1, cnt == 1, cnt == 0, cnt > 1}));
      chk(respPhys == ph, req, respPhys, ph);
    end
    for (int i = 0; i < N; i++) begin
      m = msk(mSize[i]);
      if (fa && !mPres[i]) mValid[i] = 0;
      if (fo && ((fadr & m) == ({mTag[i], 12'h0} & m))) mValid[i] = 0;
    end
    if (ld && !mis) begin
      mTag[idx] = cam[31:12]; mSize[idx] = cam[2:1]; mPres[idx] = cam[3];
      mValid[idx] = 1; mRam[idx] = ram;
    end
  endtask

  task automatic lookupOnly(input logic [31:0] a);
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 1, a);
  endtask

  task automatic loadOnly(input int idx, input logic [31:0] cam, input logic [31:0] ram);
    step(1, idx, cam, ram, 0, 0, 32'h0, 0, 32'h0);
  endtask

  function automatic logic [31:0] randCam();
    logic [31:0] c, m;
    logic [1:0] sz;
    sz = 2'($urandom_range(0, 3));
    c = {($urandom_range(0, 1) != 0) ? 8'h20 : 8'h10,
         4'($urandom_range(0, 1)), 4'($urandom_range(0, 1)),
         4'($urandom_range(0, 1)), 12'h000};
    m = msk(sz);
    if ($urandom_range(0, 5) != 0) c = c & m;
    c[3] = 1'($urandom_range(0, 3) == 0);
    c[2:1] = sz;
    c[0] = 1'($urandom);
    return c;
  endfunction

  function automatic logic [31:0] randAddr();
    return {($urandom_range(0, 1) != 0) ? 8'h20 : 8'h10,
            4'($urandom_range(0, 1)), 4'($urandom_range(0, 1)),
            4'($urandom_range(0, 1)), 12'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = int'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      mTag[i] = '0; mSize[i] = '0; mPres[i] = 0; mValid[i] = 0; mRam[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({respValid, respHit, respMiss, respMulti, loadErr} == 5'b0, "R1",
        32'({respValid, respHit, respMiss, respMulti, loadErr}), 32'h0);
    checkAll("R1");

    // R2, R3: one slot per page size
    loadOnly(0, 32'h1000_0000 | (2'd0 << 1), 32'hA000_0ABC); // 16M
    loadOnly(1, 32'h2030_0000 | (2'd1 << 1) | 32'h8, 32'hB120_0000); // 1M, protected
    loadOnly(2, 32'h3045_0000 | (2'd2 << 1) | 32'hFF0, 32'hC678_0000); // 64K, ignored bits
    loadOnly(3, 32'h4001_2000 | (2'd3 << 1) | 32'h8, 32'hD000_5000); // 4K, protected
    checkAll("R3");
    lookupOnly(32'h1012_3456);
    chk(respPhys == 32'hA012_3456, "R2 16M", respPhys, 32'hA012_3456);
    lookupOnly(32'h203A_BCDE);
    chk(respPhys == 32'hB12A_BCDE, "R2 1M", respPhys, 32'hB12A_BCDE);
    lookupOnly(32'h3045_9876);
    chk(respPhys == 32'hC678_9876, "R2 64K", respPhys, 32'hC678_9876);
    lookupOnly(32'h4001_2FFF);
    chk(respPhys == 32'hD000_5FFF, "R2 4K", respPhys, 32'hD000_5FFF);
    // R5: no response without request
    @(negedge clk);
    chk({respValid, respHit, respMiss, respMulti} == 4'b0, "R5 idle",
        32'({respValid, respHit, respMiss, respMulti}), 32'h0);
    // R4: misaligned load leaves slot untouched
    loadOnly(4, 32'h5080_0000 | (2'd0 << 1), 32'h1111_1111);
    checkAll("R4");
    // R6: miss
    lookupOnly(32'h7700_0000);
    chk(respMiss == 1'b1, "R6", 32'(respMiss), 32'h1);
    // R7: overlapping 16M and 64K slots
    loadOnly(5, 32'h1055_0000 | (2'd2 << 1), 32'hE000_0000);
    lookupOnly(32'h1055_1234);
    chk(respMulti == 1'b1, "R7", 32'(respMulti), 32'h1);
    // R10: directed flush removes the 16M slot, R8 then a single hit
    step(0, 0, 32'h0, 32'h0, 0, 1, 32'h10FF_0000, 0, 32'h0);
    checkAll("R10");
    lookupOnly(32'h1055_1234);
    chk(respHit == 1'b1, "R8", 32'(respHit), 32'h1);
    // R10: directed flush hits a protected slot
    step(0, 0, 32'h0, 32'h0, 0, 1, 32'h4001_2000, 0, 32'h0);
    checkAll("R10 protected");
    // R9: global flush keeps protected slot 1 only
    step(0, 0, 32'h0, 32'h0, 1, 0, 32'h0, 0, 32'h0);
    checkAll("R9");
    chk(readCam[0] == 1'b0, "R9", 32'(readCam[0]), 32'h0);
    // R11: load + global flush + lookup in one cycle
    step(1, 6, 32'h2030_0000 | (2'd1 << 1), 32'h9990_0000, 1, 0, 32'h0, 1, 32'h2031_0000);
    checkAll("R11");
    lookupOnly(32'h2031_0000);
    chk(respMulti == 1'b1, "R11", 32'(respMulti), 32'h1);

    // Random mix, R12 readback at intervals
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (op < 40) lookupOnly(randAddr());
      else if (op < 70) loadOnly(int'($urandom_range(0, N - 1)), randCam(), $urandom);
      else if (op < 72) step(0, 0, 32'h0, 32'h0, 1, 0, 32'h0, 1, randAddr());
      else if (op < 82) step(0, 0, 32'h0, 32'h0, 0, 1, randAddr(), 1, randAddr());
      else step(1, int'($urandom_range(0, N - 1)), randCam(), $urandom,
                $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0, randAddr(),
                1, randAddr());
      if (it % 50 == 49) checkAll("R12");
    end
    checkAll("R12 final");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule